// File: doc/BRIEF.md
# Registered Stream Decoupling Buffer

This block sits on a valid/ready stream and separates its producer side from its consumer side. Each word that is accepted at the input leaves at the output unchanged and in order. When the buffer is empty, a word appears at the output one cycle after it is written. No combinational path runs from an input-side signal to an output-side signal. This holds for data and valid going forward and for ready going back. Two blocks can therefore be chained without long timing paths or loops, and the stream still moves one word per cycle.

Storage is a circular buffer with `DEPTH` slots, two entries by default. It has a write pointer, a read pointer and an occupancy count. A small controller tracks three named states:

- **EMPTY**: no entry held.
- **PARTIAL**: between one and `DEPTH-1` entries held.
- **FULL**: `DEPTH` entries held.

The transitions are:

- *fill_first*: EMPTY to PARTIAL, on a write with no read.
- *fill_last*: PARTIAL to FULL, on a write with no read while holding `DEPTH-1` entries.
- *drain_last*: PARTIAL to EMPTY, on a read with no write while holding one entry.
- *drain_first*: FULL to PARTIAL, on a read.

In every other case the state is held; this includes a simultaneous write and read. Input ready and output valid are decoded from the state register alone. A transfer takes place on a port when its valid and ready are both high at a rising edge. Both ports use one clock and an active-high synchronous reset. `DEPTH` must be at least two for full throughput.

Top module: `stream_decoupler`

## Requirements
- R1: While and just after synchronous reset, out_valid is 0 and in_ready is 1 (the buffer is empty).
- R2: A word written into an empty buffer at a rising edge is presented on out_data with out_valid high right after that edge, which gives one cycle of latency.
- R3: The sequence of words delivered at the output equals the sequence accepted at the input, with no loss, duplication or reordering, under any valid/ready pattern.
- R4: in_ready equals (occupancy < DEPTH) and out_valid equals (occupancy > 0). Changing out_ready or in_valid within a cycle changes neither of them.
- R5: While DEPTH words are held, in_ready is 0 and a word offered on in_data is not taken.
- R6: With in_valid and out_ready held high, one word is delivered every cycle, and a simultaneous write and read leaves the occupancy unchanged.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays stable.
- R8: If the consumer becomes ready two cycles after the producer starts writing continuously, the buffer absorbs the backlog and then delivers one word every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | WIDTH | Word offered by the producer |
| in_valid | input | 1 | Producer has a word on in_data |
| in_ready | output | 1 | Buffer can take a word this cycle |
| out_data | output | WIDTH | Oldest held word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer takes the word this cycle |

## Verification
Occupancy changes at the edge where a handshake happens, and both status outputs follow in the cycle that starts at that edge. So in_ready, out_valid and out_data are due one edge after the stimulus that moved them, and a first word is due at the edge right after its write (R2). The bench drives its inputs shortly after each falling edge. It updates its queue model at the rising edge from the driven inputs and the model's own occupancy. It compares all three outputs at the next falling edge, once every edge has settled. Within the same cycle it toggles out_ready and in_valid and re-samples, to show that neither status output reacts before the next edge.

// File: rtl/stream_decoupler_pkg.sv
package stream_decoupler_pkg;

    // Occupancy class of the circular buffer
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } dcp_state_e;

endpackage

// File: rtl/dcp_ptr.sv
// Circular slot pointer; wraps after DEPTH-1.
module dcp_ptr #(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [PW-1:0] ptr
);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_d;

    generate
        if ((1 << PW) == DEPTH) begin : g_pow2
            // natural wrap on power-of-two depth
            always_comb ptr_d = ptr_q + PW'(1);
        end else begin : g_wrap
            always_comb ptr_d = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/dcp_store.sv
// Slot registers with registered-pointer read selection.
module dcp_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_data
);

    logic [DEPTH-1:0][WIDTH-1:0] slots;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [WIDTH-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q <= '0;
                end else if (wr_en && (wr_ptr == PW'(i))) begin
                    slot_q <= wr_data;
                end
            end
            assign slots[i] = slot_q;
        end
    endgenerate

    // selection depends only on the registered read pointer
    assign rd_data = slots[rd_ptr];

endmodule

// File: rtl/dcp_ctrl.sv
// Occupancy controller: state register, next-state logic, state-decoded outputs.
module dcp_ctrl
    import stream_decoupler_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic push,
    output logic pop
);

    localparam logic [CW-1:0] CNT_TOP  = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    dcp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // handshakes; both ready and valid here come from state only
    assign push = in_valid && in_ready;
    assign pop  = out_valid && out_ready;

    // occupancy update
    always_comb begin
        cnt_d = cnt_q;
        unique case ({push, pop})
            2'b10:   cnt_d = cnt_q + CNT_ONE;
            2'b01:   cnt_d = cnt_q - CNT_ONE;
            default: cnt_d = cnt_q;
        endcase
    end

    // next state: named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) begin
                    // fill_first
                    state_d = (cnt_d == CNT_TOP) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (push && !pop && (cnt_q == CNT_LAST)) begin
                    // fill_last
                    state_d = ST_FULL;
                end else if (pop && !push && (cnt_q == CNT_ONE)) begin
                    // drain_last
                    state_d = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (pop && !push) begin
                    // drain_first
                    state_d = (cnt_d == '0) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs decoded from state only
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_PARTIAL: begin
                in_ready  = 1'b1;
                out_valid = 1'b1;
            end
            ST_FULL: begin
                in_ready  = 1'b0;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stream_decoupler.sv
module stream_decoupler #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          push, pop;
    logic [PW-1:0] wr_ptr, rd_ptr;

    dcp_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .push      (push),
        .pop       (pop)
    );

    dcp_ptr #(.DEPTH(DEPTH)) wr_ptr_i (
        .clk  (clk),
        .rst  (rst),
        .step (push),
        .ptr  (wr_ptr)
    );

    dcp_ptr #(.DEPTH(DEPTH)) rd_ptr_i (
        .clk  (clk),
        .rst  (rst),
        .step (pop),
        .ptr  (rd_ptr)
    );

    dcp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_ptr  (wr_ptr),
        .wr_data (in_data),
        .rd_ptr  (rd_ptr),
        .rd_data (out_data)
    );

endmodule

// File: rtl/stream_decoupler_chk.sv
module stream_decoupler_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] in_data,
    input logic             in_valid,
    input logic             in_ready,
    input logic [WIDTH-1:0] out_data,
    input logic             out_valid,
    input logic             out_ready
);

    // occupancy seen from the port handshakes
    int occ;
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= 0;
        end else begin
            occ <= occ + int'(in_valid && in_ready) - int'(out_valid && out_ready);
        end
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && in_ready));

    // R2
    first_word_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !out_valid) |=> (out_valid && out_data == $past(in_data)));

    // R4
    ready_level_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready == (occ < DEPTH));

    // R4
    valid_level_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == (occ > 0));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (occ <= DEPTH) && (occ >= 0));

    // R6
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && out_valid && out_ready) |=> (in_ready && out_valid));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind stream_decoupler stream_decoupler_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/stream_decoupler_tb.sv
module stream_decoupler_tb_top;

    localparam int WIDTH = 16;
    localparam int DEPTH = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_valid = 1'b0;
    logic             out_ready = 1'b0;
    logic             in_ready;
    logic             out_valid;
    logic [WIDTH-1:0] out_data;

    always #4 clk = ~clk;  // 125 MHz

    stream_decoupler #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    int               checks = 0;
    int               failures = 0;
    int               pops = 0;
    bit               done = 1'b0;
    logic [WIDTH-1:0] model_q[$];
    logic [WIDTH-1:0] next_word = 16'h0100;
    logic [15:0]      lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one cycle: compare at falling edge, drive, update model at rising edge
    task automatic cycle(input bit v, input bit r, input bit probe);
        bit exp_rdy, exp_vld, rdy0, vld0, push, pop;
        @(negedge clk);
        exp_rdy = (model_q.size() < DEPTH);
        exp_vld = (model_q.size() > 0);
        check(in_ready == exp_rdy, exp_rdy ? "R4" : "R5", "in_ready",
              longint'(in_ready), longint'(exp_rdy));
        check(out_valid == exp_vld, "R4", "out_valid",
              longint'(out_valid), longint'(exp_vld));
        if (exp_vld) begin
            check(out_data == model_q[0], out_ready ? "R3" : "R7", "out_data",
                  longint'(out_data), longint'(model_q[0]));
        end
        if (probe) begin
            // R4: same-cycle input changes must not reach the status outputs
            rdy0 = in_ready;
            vld0 = out_valid;
            out_ready = ~out_ready;
            in_valid  = ~in_valid;
            #1;
            check(in_ready == rdy0, "R4", "in_ready vs out_ready",
                  longint'(in_ready), longint'(rdy0));
            check(out_valid == vld0, "R4", "out_valid vs in_valid",
                  longint'(out_valid), longint'(vld0));
        end
        #1;
        in_valid  = v;
        out_ready = r;
        in_data   = next_word;
        @(posedge clk);
        push = v && (model_q.size() < DEPTH);
        pop  = r && (model_q.size() > 0);
        if (pop) begin
            void'(model_q.pop_front());
            pops++;
        end
        if (push) begin
            model_q.push_back(next_word);
            next_word = next_word + 16'd7;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int start_pops;
        logic [WIDTH-1:0] w;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);

        // R2: single word latency
        w = next_word;
        cycle(1'b1, 1'b0, 1'b0);
        #2;
        check(out_valid == 1'b1, "R2", "out_valid one cycle after write",
              longint'(out_valid), 1);
        check(out_data == w, "R2", "out_data one cycle after write",
              longint'(out_data), longint'(w));

        // R5: fill, then keep offering while full; R7: stalled output holds
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 1'b1);
        check(model_q.size() == DEPTH, "R5", "model held words",
              longint'(model_q.size()), DEPTH);
        // drain fully; order check covers that nothing extra was taken (R5)
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0);
        check(model_q.size() == 0, "R5", "drained count", longint'(model_q.size()), 0);

        // R3 R4 R7: pseudo-random valid/ready patterns with probing
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0] | lfsr[5], lfsr[3] ^ lfsr[9], (i % 5) == 0);
        end
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0);

        // R6: both sides always willing
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b0);
        start_pops = pops;
        for (int i = 0; i < 50; i++) cycle(1'b1, 1'b1, 1'b0);
        check(pops - start_pops == 50, "R6", "words in 50 streaming cycles",
              longint'(pops - start_pops), 50);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0);

        // R8: consumer joins two cycles late, then must run gap-free
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b1, 1'b0, 1'b0);
        start_pops = pops;
        for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 1'b0);
        check(pops - start_pops == 40, "R8", "words after late consumer",
              longint'(pops - start_pops), 40);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0);
        check(model_q.size() == 0, "R3", "final occupancy", longint'(model_q.size()), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule